// File: doc/BRIEF.md
# Phase-Shifted Bridge and Cycloconverter Gate Generator

This block produces every gate signal for a stack of high-frequency AC-link inverter modules from one up/down counter. The counter forms a symmetric triangle carrier. The four primary full-bridge switches are driven as two complementary legs. Leg B lags leg A by a programmable number of cycles, and each leg has a programmable dead time. Two sync lines mark the rising and falling halves of the carrier. These lines are steered onto the four secondary bidirectional switches by a polarity bit, which reports the sign of one sensed inductor current. Each of the eight gate lines goes to the switch in the same position in every module. All modules therefore switch in lockstep and no current can circulate between them.

The half-period count, the phase shift and the dead time are plain control pins. The half-period and the phase shift are held in active registers. These registers reload only when the carrier passes its valley. The polarity bit is sampled only at a peak or a valley, so a secondary pulse is never cut short. At a 100 MHz clock, a half-period of 2994 gives about 16.7 kHz switching.

Top module: `acl_gate_gen`

## Requirements
- R1: While `rst_n` is low, all eight gate outputs are 0, with no clock needed.
- R2: The carrier period is 2*P clock cycles. P is `period_i`, raised to 2 when it is below 2. The period is seen as the spacing between successive rises of the rising-half secondary line (bit 1 OR bit 3 of `sec_gate_o`).
- R3: P and the phase shift are loaded only at a carrier valley. After reset, P is the parameter `DEF_PERIOD` and the shift is 0 until the first valley. A change made in mid-period leaves the current period at its old length.
- R4: Primary bit positions are: bit 0 leg A high side, bit 1 leg A low side, bit 2 leg B high side, bit 3 leg B low side. The leg A high side rises exactly d+1 cycles after the rising-half secondary line rises, where d is `dead_i`.
- R5: The leg B high side rises S cycles after the leg A high side. S is `shift_i`, capped at P.
- R6: The dead time d must be below P. In each leg, both gates are low for exactly d cycles at every transition. The high side stays on for P-d cycles.
- R7: Secondary bit positions are: bit 0 = falling half AND polarity, bit 1 = rising half AND polarity, bit 2 = falling half AND NOT polarity, bit 3 = rising half AND NOT polarity. From the first clock after reset, exactly one secondary line is high in every cycle.
- R8: `pol_i` is sampled only at the clock edge that starts a carrier half. A change in mid-half lets the running secondary pulse finish its full P cycles. The new routing applies from the next half.
- R9: While polarity is held high, bits 2 and 3 of `sec_gate_o` stay low and bits 0 and 1 alternate. While polarity is held low, the roles are swapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_i | input | CNT_W | Carrier half-period in cycles (loaded at valley) |
| shift_i | input | CNT_W | Leg B lag in cycles (loaded at valley) |
| dead_i | input | DT_W | Dead time in cycles per leg transition |
| pol_i | input | 1 | Inductor-current polarity, 1 = positive |
| pri_gate_o | output | 4 | Primary bridge gates, shared by all modules |
| sec_gate_o | output | 4 | Secondary switch gates, shared by all modules |

## Verification
The hardest case to reach from the pins is a polarity flip or a new half-period that arrives partway through a carrier half. The bench finds a half boundary by watching for a secondary sync line to rise. It counts cycles from that edge and changes the input at a known mid-half point. It then measures the running pulse or period to confirm it kept its old length, and the next one to confirm it follows the new value. Randomised half-periods, shifts and dead times, including values below the clamp limits, are checked against offsets measured from that same valley marker.

// File: rtl/acl_pkg.sv
package acl_pkg;
  // smallest legal carrier half-period in cycles
  localparam int unsigned MIN_HALF = 2;
  // number of primary bridge legs
  localparam int unsigned N_LEGS = 2;

  typedef enum logic {
    HALF_FALL = 1'b0,
    HALF_RISE = 1'b1
  } half_e;

  typedef logic [3:0] gate4_t;
endpackage

// File: rtl/acl_carrier.sv
module acl_carrier
  import acl_pkg::*;
#(
  parameter int unsigned CNT_W      = 12,
  parameter int unsigned DEF_PERIOD = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] shift_i,
  output logic [CNT_W-1:0] cnt_o,
  output half_e            half_o,
  output logic [CNT_W-1:0] per_o,
  output logic [CNT_W-1:0] shf_o,
  output logic             bnd_o
);
  localparam logic [CNT_W-1:0] MIN_P = CNT_W'(MIN_HALF);
  localparam logic [CNT_W-1:0] DEF_P =
    (DEF_PERIOD < MIN_HALF) ? MIN_P : CNT_W'(DEF_PERIOD);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, per_q, shf_q;
  half_e            half_q;
  logic [CNT_W-1:0] per_nxt, shf_nxt;
  logic             at_top, at_bot;

  always_comb begin
    per_nxt = (period_i < MIN_P) ? MIN_P : period_i;
    shf_nxt = (shift_i > per_nxt) ? per_nxt : shift_i;
  end

  assign at_top = (half_q == HALF_RISE) && (cnt_q == per_q - ONE);
  assign at_bot = (half_q == HALF_FALL) && (cnt_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= HALF_RISE;
      per_q  <= DEF_P;
      shf_q  <= '0;
    end else if (at_top) begin
      cnt_q  <= cnt_q + ONE;
      half_q <= HALF_FALL;
    end else if (at_bot) begin
      cnt_q  <= '0;
      half_q <= HALF_RISE;
      per_q  <= per_nxt;
      shf_q  <= shf_nxt;
    end else if (half_q == HALF_RISE) begin
      cnt_q <= cnt_q + ONE;
    end else begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign cnt_o  = cnt_q;
  assign half_o = half_q;
  assign per_o  = per_q;
  assign shf_o  = shf_q;
  assign bnd_o  = at_top | at_bot;

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= per_q);

  // R3
  reload_valley_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(per_q) || !$stable(shf_q)) |-> (cnt_q == '0));
endmodule

// File: rtl/acl_deadband.sv
module acl_deadband #(
  parameter int unsigned DT_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            raw_i,
  input  logic [DT_W-1:0] dead_i,
  output logic            hi_o,
  output logic            lo_o
);
  logic            lvl_q;
  logic [DT_W-1:0] tmr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      tmr_q <= '0;
    end else if (raw_i != lvl_q) begin
      lvl_q <= raw_i;
      tmr_q <= dead_i;
    end else if (tmr_q != '0) begin
      tmr_q <= tmr_q - DT_W'(1);
    end
  end

  assign hi_o = lvl_q  && (tmr_q == '0);
  assign lo_o = !lvl_q && (tmr_q == '0);
endmodule

// File: rtl/acl_pri_pwm.sv
module acl_pri_pwm
  import acl_pkg::*;
#(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned DT_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  half_e            half_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] shf_i,
  input  logic [DT_W-1:0]  dead_i,
  output gate4_t           pri_o
);
  logic [N_LEGS-1:0] leg_raw, leg_hi, leg_lo;
  logic              rising;

  assign rising = (half_i == HALF_RISE);

  // leg A follows the carrier half; leg B uses a pair of compare values
  assign leg_raw[0] = rising;
  assign leg_raw[1] = rising ? (cnt_i >= shf_i) : (cnt_i > (per_i - shf_i));

  for (genvar g = 0; g < N_LEGS; g++) begin : g_leg
    acl_deadband #(.DT_W(DT_W)) u_db (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (leg_raw[g]),
      .dead_i (dead_i),
      .hi_o   (leg_hi[g]),
      .lo_o   (leg_lo[g])
    );
    assign pri_o[2*g]   = leg_hi[g];
    assign pri_o[2*g+1] = leg_lo[g];
  end
endmodule

// File: rtl/acl_sec_steer.sv
module acl_sec_steer
  import acl_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pol_i,
  input  logic   bnd_i,
  input  half_e  half_i,
  output gate4_t sec_o
);
  logic pol_q;
  logic rise_s, fall_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pol_q <= 1'b0;
    else if (bnd_i) pol_q <= pol_i;
  end

  assign rise_s = (half_i == HALF_RISE);
  assign fall_s = (half_i == HALF_FALL);

  assign sec_o[0] = fall_s &  pol_q;
  assign sec_o[1] = rise_s &  pol_q;
  assign sec_o[2] = fall_s & ~pol_q;
  assign sec_o[3] = rise_s & ~pol_q;

  // R8
  pol_bnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pol_q) |-> $past(bnd_i));
endmodule

// File: rtl/acl_gate_gen.sv
module acl_gate_gen
  import acl_pkg::*;
#(
  parameter int unsigned CNT_W      = 12,
  parameter int unsigned DT_W       = 6,
  parameter int unsigned DEF_PERIOD = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] shift_i,
  input  logic [DT_W-1:0]  dead_i,
  input  logic             pol_i,
  output logic [3:0]       pri_gate_o,
  output logic [3:0]       sec_gate_o
);
  logic [CNT_W-1:0] cnt, per, shf;
  half_e            half;
  logic             bnd;
  gate4_t           pri_d, sec_d, pri_q, sec_q;

  acl_carrier #(.CNT_W(CNT_W), .DEF_PERIOD(DEF_PERIOD)) u_car (
    .clk      (clk),
    .rst_n    (rst_n),
    .period_i (period_i),
    .shift_i  (shift_i),
    .cnt_o    (cnt),
    .half_o   (half),
    .per_o    (per),
    .shf_o    (shf),
    .bnd_o    (bnd)
  );

  acl_pri_pwm #(.CNT_W(CNT_W), .DT_W(DT_W)) u_pri (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_i  (cnt),
    .half_i (half),
    .per_i  (per),
    .shf_i  (shf),
    .dead_i (dead_i),
    .pri_o  (pri_d)
  );

  acl_sec_steer u_sec (
    .clk    (clk),
    .rst_n  (rst_n),
    .pol_i  (pol_i),
    .bnd_i  (bnd),
    .half_i (half),
    .sec_o  (sec_d)
  );

  // glitch-free registered outputs, cleared asynchronously
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_q <= '0;
      sec_q <= '0;
    end else begin
      pri_q <= pri_d;
      sec_q <= sec_d;
    end
  end

  assign pri_gate_o = pri_q;
  assign sec_gate_o = sec_q;

  // R6
  leg_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pri_q[0] && pri_q[1]) && !(pri_q[2] && pri_q[3]));

  // R7
  sec_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($countones(sec_q) == 1));
endmodule

// File: tb/acl_gate_gen_test.sv
module acl_gate_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEFP = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] period_i = 12'd6;
  logic [11:0] shift_i = 12'd0;
  logic [5:0]  dead_i = 6'd0;
  logic        pol_i = 1'b1;
  logic [3:0]  pri, sec;

  int tests = 0, fails = 0, cyc = 0, mon_err = 0;
  bit mon_en = 0, done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  acl_gate_gen #(.CNT_W(12), .DT_W(6), .DEF_PERIOD(DEFP)) uut (
    .clk(clk), .rst_n(rst_n), .period_i(period_i), .shift_i(shift_i),
    .dead_i(dead_i), .pol_i(pol_i), .pri_gate_o(pri), .sec_gate_o(sec)
  );

  wire upq = sec[1] | sec[3];

  // R7 monitor: exactly one secondary line each cycle
  always @(negedge clk)
    if (mon_en && rst_n && ($countones(sec) != 1)) mon_err++;

  function automatic int eff_per(int p);
    return (p < 2) ? 2 : p;
  endfunction
  function automatic int eff_shf(int s, int p);
    return (s > eff_per(p)) ? eff_per(p) : s;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_up_rise(output int t);
    bit prev = upq;
    forever begin
      @(negedge clk);
      if (upq && !prev) break;
      prev = upq;
    end
    t = cyc;
  endtask

  // called at the negedge where the rising-half line has just risen
  task automatic measure(input int p, input int s, input int d, input bit pol);
    int pe = eff_per(p), se = eff_shf(s, p);
    int a_r = -1, b_r = -1, a_f = -1, l_r = -1, u_r = -1;
    logic [3:0] pp = pri;
    bit pu = upq;
    for (int k = 1; k <= 2*pe; k++) begin
      @(negedge clk);
      if (pri[0] && !pp[0] && a_r < 0) a_r = k;
      if (!pri[0] && pp[0] && a_f < 0) a_f = k;
      if (pri[1] && !pp[1] && l_r < 0) l_r = k;
      if (pri[2] && !pp[2] && b_r < 0) b_r = k;
      if (upq && !pu && u_r < 0) u_r = k;
      if (k == 1)    chk("R9 rising-half line", int'(sec), pol ? 2 : 8);
      if (k == pe+1) chk("R9 falling-half line", int'(sec), pol ? 1 : 4);
      pp = pri; pu = upq;
    end
    chk("R2 period", u_r, 2*pe);
    chk("R4 leg A high rise offset", a_r, d + 1);
    chk("R5 leg B lag", b_r - a_r, se);
    chk("R6 high-side on time", a_f - a_r, pe - d);
    chk("R6 dead gap", l_r - a_f, d);
  endtask

  task automatic apply_and_measure(input int p, input int s, input int d, input bit pol);
    int t;
    @(negedge clk);
    period_i = 12'(p); shift_i = 12'(s); dead_i = 6'(d); pol_i = pol;
    wait_up_rise(t);
    wait_up_rise(t);
    measure(p, s, d, pol);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int t1, t2, t3, len, pe;
    void'($urandom(32'd4711));
    // R1: outputs low in reset
    repeat (5) @(negedge clk);
    chk("R1 pri in reset", int'(pri), 0);
    chk("R1 sec in reset", int'(sec), 0);
    rst_n = 1'b1;
    // R3: default period until first valley, then period_i=6
    wait_up_rise(t1);
    mon_en = 1;
    wait_up_rise(t2);
    wait_up_rise(t3);
    chk("R3 default period", t2 - t1, 2*DEFP);
    chk("R3 new period after valley", t3 - t2, 12);

    // R3: mid-period change keeps the running period
    apply_and_measure(6, 2, 1, 1'b1);
    wait_up_rise(t1);
    repeat (2) @(negedge clk);
    period_i = 12'd9; shift_i = 12'd5;
    wait_up_rise(t2);
    chk("R3 running period kept", t2 - t1, 12);
    measure(9, 5, 1, 1'b1);

    // R8: polarity change mid-half never truncates a pulse
    apply_and_measure(8, 3, 2, 1'b1);
    wait_up_rise(t1);
    len = 1;
    forever begin
      @(negedge clk);
      if (len == 4) pol_i = 1'b0;
      if (sec[1]) len++; else break;
    end
    chk("R8 Q2 pulse length", len, 8);
    chk("R8 routing after peak", int'(sec), 4);
    len = 1;
    forever begin
      @(negedge clk);
      if (len == 3) pol_i = 1'b1;
      if (sec[2]) len++; else break;
    end
    chk("R8 Q3 pulse length", len, 8);
    chk("R8 routing after valley", int'(sec), 2);

    // R2/R5 clamps
    apply_and_measure(1, 7, 0, 1'b0);
    apply_and_measure(5, 30, 2, 1'b1);

    // random patterns
    for (int i = 0; i < 12; i++) begin
      int p = ($urandom % 5 == 0) ? int'($urandom % 2) : 2 + int'($urandom % 30);
      int s;
      int d;
      pe = eff_per(p);
      s = int'($urandom % (pe + 4));
      d = int'($urandom % pe);
      apply_and_measure(p, s, d, 1'($urandom % 2));
    end

    // R1: asynchronous reset mid-run
    @(negedge clk);
    #1 rst_n = 1'b0;
    mon_en = 0;
    #1;
    chk("R1 pri async clear", int'(pri), 0);
    chk("R1 sec async clear", int'(sec), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    chk("R7 one-hot secondary monitor", mon_err, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule